// File: doc/BRIEF.md
# Latched-Address Word Memory with Complemented Readout

This block is a small read/write store of sixteen 4-bit words, accessed through one active-low select and one active-low write strobe. An access opens when the select line goes from high to low. At that moment an internal register takes the address. For the rest of the access the address pins are ignored, so a shared address bus is free to move on.

While the access is open, a low write strobe stores the data inputs into the captured word. A high write strobe puts that word on the outputs with every bit inverted. The outputs mimic a three-state bus: a data vector plus a drive flag. The drive flag is low whenever the block is not selected or is writing.

All inputs pass through a parameterised synchroniser onto the system clock. The select line is then edge-detected there. Width and depth are parameters; the defaults give 16 words of 4 bits.

Top module: `latch_addr_ram`

## Requirements
- R1: The store holds 2**ADDR_W words of DATA_W bits (default 16 x 4), and each word is chosen by the binary value of the address bus.
- R2: The address register loads the address bus only when the synchronised select changes from high to low. If the select has been held low since reset, no access is opened and `dout_oe` stays 0.
- R3: Once an access is open, a change on `addr` affects neither which word is read nor which word is written.
- R4: While an access is open and `we_n` is 0, `din` is stored into the captured word.
- R5: While an access is open and `we_n` is 1, `dout_oe` is 1 and `dout` equals the bitwise complement of the captured word.
- R6: Reading never changes any stored word; repeated reads return the same value.
- R7: `dout_oe` is 0 while `me_n` is 1 and while a write is in progress.
- R8: After reset `dout_oe` is 0, `dout` is all zeros and the address register is cleared.
- R9: A read that directly follows a write in the same access shows the complement of the newly written value.
- R10: Every cycle with both strobes low rewrites the same captured word, so the last data held at the end of a write burst is the value stored.
- R11: A change on the inputs reaches the outputs SYNC_STAGES+1 clock cycles later, because of the input synchroniser and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| me_n | input | 1 | Active-low memory select; its high-to-low change opens an access |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address, sampled when an access opens |
| din | input | DATA_W | Data to store |
| dout | output | DATA_W | Complement of the captured word during a read, zero otherwise |
| dout_oe | output | 1 | High when `dout` is driven (a read is in progress) |

## Verification
The assertions assume that `me_n`, `we_n`, `addr` and `din` travel through the synchroniser as one group. A select edge and the address that goes with it must therefore be applied in the same cycle. The address may only move after that cycle. The stimulus does exactly this: it raises `me_n` for several cycles, sets the address and lowers `me_n` together, and changes `addr` to a random value one cycle later. The assertions on stored contents also take it as given that no word is read before it has been written. The bench keeps a written-flag per word and writes a word before its first read.

// File: rtl/latram_pkg.sv
package latram_pkg;

   // control strobes travel together through the input synchroniser
   typedef struct packed {
      logic me_n;
      logic we_n;
   } ctl_t;

   // what the memory does in the current cycle
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'b00,
      ACC_READ  = 2'b01,
      ACC_WRITE = 2'b10
   } acc_e;

   localparam int unsigned CTL_W = $bits(ctl_t);

endpackage

// File: rtl/input_sync.sv
module input_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] RST_WORD = {WIDTH{RST_VAL}};

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("input_sync: WIDTH must be at least 1");
      end
      if (STAGES < 1) begin : g_bad_stages
         $error("input_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_WORD;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_WORD;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              me_n_s,
   input  logic [ADDR_W-1:0] addr_s,
   output logic              fall,
   output logic              live,
   output logic [ADDR_W-1:0] addr_eff
);

   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("addr_capture: ADDR_W must be at least 1");
      end
   endgenerate

   logic              me_n_d;
   logic              selected;
   logic [ADDR_W-1:0] addr_q;

   // previous select sample; reset low so a select held low from reset gives no edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) me_n_d <= 1'b0;
      else        me_n_d <= me_n_s;
   end

   assign fall = me_n_d & ~me_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      selected <= 1'b0;
      else if (me_n_s) selected <= 1'b0;
      else if (fall)   selected <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (fall) addr_q <= addr_s;
   end

   // the detect cycle already works on the freshly captured address
   assign live     = ~me_n_s & (selected | fall);
   assign addr_eff = fall ? addr_s : addr_q;

   // R2
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> (addr_q == $past(addr_s)));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(addr_q));

   // R2
   sel_via_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(selected) |-> $past(fall));

   // R7
   sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      me_n_s |=> !selected);

endmodule

// File: rtl/word_store.sv
module word_store #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_word
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("word_store: DATA_W must be at least 1");
      end
      if (ADDR_W > 10) begin : g_bad_depth
         $error("word_store: ADDR_W above 10 makes the array too large");
      end
   endgenerate

   // contents are left uninitialised on purpose
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wr_data;
   end

   assign rd_word = mem[addr];

   // R4
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(addr)] == $past(wr_data)));

   // R6
   rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (mem[$past(addr)] == $past(mem[addr])));

endmodule

// File: rtl/latch_addr_ram.sv
module latch_addr_ram #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              me_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);

   import latram_pkg::*;

   localparam int unsigned BUS_W = ADDR_W + DATA_W;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("latch_addr_ram: SYNC_STAGES must be at least 1");
      end
   endgenerate

   ctl_t              ctl_in;
   ctl_t              ctl_s;
   logic [BUS_W-1:0]  bus_in;
   logic [BUS_W-1:0]  bus_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;

   assign ctl_in = '{me_n: me_n, we_n: we_n};
   assign bus_in = {addr, din};

   input_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_in),
      .q     (ctl_s)
   );

   input_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_in),
      .q     (bus_s)
   );

   assign addr_s = bus_s[BUS_W-1:DATA_W];
   assign din_s  = bus_s[DATA_W-1:0];

   logic              fall;
   logic              live;
   logic [ADDR_W-1:0] addr_eff;

   addr_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .me_n_s   (ctl_s.me_n),
      .addr_s   (addr_s),
      .fall     (fall),
      .live     (live),
      .addr_eff (addr_eff)
   );

   acc_e acc;
   always_comb begin
      if (!live)          acc = ACC_IDLE;
      else if (ctl_s.we_n) acc = ACC_READ;
      else                acc = ACC_WRITE;
   end

   logic [DATA_W-1:0] rd_word;

   word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc == ACC_WRITE),
      .addr    (addr_eff),
      .wr_data (din_s),
      .rd_word (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         dout_oe <= 1'b0;
      end else if (acc == ACC_READ) begin
         dout    <= ~rd_word;
         dout_oe <= 1'b1;
      end else begin
         dout    <= '0;
         dout_oe <= 1'b0;
      end
   end

   // R7
   oe_hiz_me_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_s.me_n |=> !dout_oe);

   // R7
   oe_hiz_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_s.we_n |=> !dout_oe);

   // R5
   rd_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_READ) |=> (dout_oe && (dout == ~$past(rd_word))));

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> (dout == '0));

endmodule

// File: tb/tb_latch_addr_ram.sv
module tb_latch_addr_ram;

   localparam int unsigned AW     = 4;
   localparam int unsigned DW     = 4;
   localparam int unsigned SYNC   = 2;
   localparam int unsigned DEPTH  = 1 << AW;
   localparam int unsigned SETTLE = SYNC + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          me_n = 1'b0;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_oe;

   int            n_chk = 0;
   int            n_err = 0;
   logic [DW-1:0] model [DEPTH];
   bit            wrote [DEPTH];
   bit            done = 0;

   always #2 clk = ~clk;

   latch_addr_ram #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .me_n    (me_n),
      .we_n    (we_n),
      .addr    (addr),
      .din     (din),
      .dout    (dout),
      .dout_oe (dout_oe)
   );

   function automatic logic [DW-1:0] exp_read(input logic [DW-1:0] w);
      return ~w;
   endfunction

   task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   // open an access on word a; the address bus moves away one cycle later
   task automatic open_access(input logic [AW-1:0] a, input logic [AW-1:0] junk);
      me_n = 1'b1;
      we_n = 1'b1;
      tick(SETTLE);
      check("R7 idle", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
      addr = a;
      me_n = 1'b0;
      tick(1);
      addr = junk;
      tick(SETTLE);
   endtask

   task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
      din  = d;
      we_n = 1'b0;
      tick(SETTLE);
      check("R7 write", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
      we_n = 1'b1;
      model[a] = d;
      wrote[a] = 1'b1;
      tick(SETTLE);
   endtask

   task automatic read_word(input string req, input logic [AW-1:0] a);
      check(req, {dout_oe, dout}, {1'b1, exp_read(model[a])});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < DEPTH; i++) wrote[i] = 1'b0;
      void'($urandom(32'd20240228));
      tick(3);
      // R8: outputs quiet in reset
      check("R8 in reset", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
      rst_n = 1'b1;
      tick(1);
      check("R8 after reset", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
      // R2: select low since reset opens nothing
      tick(SETTLE * 2);
      check("R2 no edge", {dout_oe, 4'h0}, {1'b0, 4'h0});

      // R1 R4 R5: fill every word and read each back
      for (int a = 0; a < DEPTH; a++) begin
         open_access(AW'(a), AW'(a + 5));
         write_word(AW'(a), DW'(a * 7 + 3));
         // R9: read straight after the write
         read_word("R9 read after write", AW'(a));
      end
      for (int a = DEPTH - 1; a >= 0; a--) begin
         open_access(AW'(a), AW'(~a));
         read_word("R1 R5 readback", AW'(a));
         tick(SETTLE);
         // R6: second read gives the same word
         read_word("R6 reread", AW'(a));
      end

      // R11: latency of the read data after select falls
      me_n = 1'b1;
      tick(SETTLE);
      addr = 4'd3;
      me_n = 1'b0;
      tick(SYNC);
      check("R11 not yet", {dout_oe, 4'h0}, {1'b0, 4'h0});
      tick(1);
      check("R11 arrives", {dout_oe, dout}, {1'b1, exp_read(model[3])});

      // R3: address moves after capture, write still lands on captured word
      open_access(4'd9, 4'd10);
      write_word(4'd9, 4'hA);
      open_access(4'd10, 4'd9);
      read_word("R3 neighbour untouched", 4'd10);
      open_access(4'd9, 4'd0);
      read_word("R3 captured word", 4'd9);

      // R10: burst of write cycles with changing data, last wins
      open_access(4'd6, 4'd1);
      we_n = 1'b0;
      for (int k = 0; k < 6; k++) begin
         din = DW'(k + 9);
         tick(1);
      end
      din = 4'h5;
      tick(SETTLE);
      check("R7 burst", {dout_oe, 4'h0}, {1'b0, 4'h0});
      we_n = 1'b1;
      model[6] = 4'h5;
      tick(SETTLE);
      read_word("R10 last data kept", 4'd6);

      // random accesses
      for (int n = 0; n < 300; n++) begin
         logic [AW-1:0] a;
         a = AW'($urandom);
         open_access(a, AW'($urandom));
         if (!wrote[a] || ($urandom % 2 == 0)) begin
            write_word(a, DW'($urandom));
            read_word("R9 random", a);
         end else begin
            read_word("R5 random", a);
         end
      end

      me_n = 1'b1;
      tick(SETTLE);
      check("R7 final idle", {dout_oe, dout}, {1'b0, {DW{1'b0}}});

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule